// File: doc/BRIEF.md
# Colour Palette Register Port

This block holds the colour lookup table of a display controller: 256 main entries plus 4 overlay entries, each with 8-bit red, green and blue parts. Software reaches it through a 32-bit register bus. It first loads a table index, then moves colour bytes through a single data port, one byte per access. The block keeps track of which colour part comes next, and it moves to the next index by itself once the blue part is done. A second data port writes the four overlay entries. It uses only the low two bits of the same index to pick one of them.

The pixel pipeline reads the table through its own combinational lookup port. It supplies an entry number and gets back the packed 24-bit colour. Bus traffic does not disturb this port, apart from the new contents that a write leaves behind.

Top module: `pal_dac_port`

## Requirements
- R1: After a synchronous active-low reset every colour part of every entry is zero, except entries 255, 256 and 258, which read back as white (0xFFFFFF). The index and the colour phase both start at zero (red).
- R2: A full-word write at byte offset 0x0 loads the index from data bits [31:24] and sets the phase back to red. This holds even in the middle of a colour sequence.
- R3: A full-word write at offset 0x4 stores data bits [31:24] into the entry the index selects. The byte goes to red, green or blue according to the phase (0 = red, 1 = green, 2 = blue), and the phase then moves one step on.
- R4: After the blue step the phase goes back to red and the index goes up by one, modulo 256, so 255 is followed by 0.
- R5: A full-word write at offset 0xC stores into overlay entry 256 + index[1:0] and follows the same phase and index stepping as R3 and R4. It leaves the main entry with the same index untouched.
- R6: A full-word read at offset 0x4 returns the current phase's part of the indexed entry in bits [31:24], with zeros below. It then steps the phase and index exactly as a data write does.
- R7: A read at any offset other than 0x4 returns zero and changes neither the index nor the phase.
- R8: Writes at any offset other than 0x0, 0x4 and 0xC are ignored. Any access whose byte enables are not all four set (0xF) is also ignored: it stores nothing, moves nothing and reads as zero.
- R9: The pixel lookup port is combinational. For an entry number from 0 to 259 it returns {red, green, blue}, with red in bits [23:16]. For any larger number it returns zero.
- R10: A colour byte written on one clock edge shows up on the pixel lookup port in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A bus access is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the access |
| req_be | input | 4 | Byte enables; only 0xF counts as a valid access |
| req_wdata | input | 32 | Write data; the colour byte and index sit in [31:24] |
| rsp_rdata | output | 32 | Combinational read data for the current access |
| pix_entry | input | 9 | Entry number asked for by the pixel pipeline |
| pix_rgb | output | 24 | Packed colour of that entry |

## Verification
The bound checker covers the sequencing rules on every cycle:
- an index load sets the phase back to red;
- each valid data access moves the phase by exactly one step;
- the index goes up, with wrap-around, only after blue;
- reads at offsets other than the data port return zero and leave the sequencer alone;
- ignored writes and partial-enable accesses leave the sequencer alone.

The table contents themselves can only be shown by the bench's scenarios, which it checks against its own model of the table. These scenarios cover the reset colours, overlay aliasing through the low index bits, the wrap from entry 255 to 0, and a write appearing on the lookup port one cycle later.

// File: rtl/pal_dac_pkg.sv
// Package: shared types and helpers for the palette register port.
// Assumes: byte offsets are compared as full 4-bit values.
package pal_dac_pkg;

    // Colour phase of the byte-serial data port
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_t;

    localparam logic [3:0] OFF_INDEX = 4'h0;
    localparam logic [3:0] OFF_MAIN  = 4'h4;
    localparam logic [3:0] OFF_OVL   = 4'hC;

    // Entries that come out of reset white
    function automatic logic rst_is_white(input int unsigned ent);
        return (ent == 255) || (ent == 256) || (ent == 258);
    endfunction

endpackage

// File: rtl/pal_decode.sv
// Module: pal_decode
// Turns one bus access into the strobes the sequencer and store act on.
// Assumes: only accesses with all byte enables set are valid; anything else is dropped.
module pal_decode #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BE_W   = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    output logic              idx_load,
    output logic              main_wr,
    output logic              ovl_wr,
    output logic              main_rd
);
    import pal_dac_pkg::*;

    logic full_acc;

    // Classify the access by direction and offset
    always_comb begin
        full_acc = req_valid && (&req_be);
        idx_load = full_acc &&  req_write && (req_addr == ADDR_W'(OFF_INDEX));
        main_wr  = full_acc &&  req_write && (req_addr == ADDR_W'(OFF_MAIN));
        ovl_wr   = full_acc &&  req_write && (req_addr == ADDR_W'(OFF_OVL));
        main_rd  = full_acc && !req_write && (req_addr == ADDR_W'(OFF_MAIN));
    end

endmodule

// File: rtl/pal_seq.sv
// Module: pal_seq
// Holds the table index and the red/green/blue phase of the data port.
// Assumes: idx_load and step are never both set (the decoder makes them exclusive).
module pal_seq #(
    parameter int unsigned IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idx_load,
    input  logic [IDX_W-1:0]      load_val,
    input  logic                  step,
    output logic [IDX_W-1:0]      cur_idx,
    output pal_dac_pkg::phase_t   cur_phase
);
    import pal_dac_pkg::*;

    // Load the index, or step the phase and bump the index after blue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            cur_phase <= PH_RED;
        end else if (idx_load) begin
            cur_idx   <= load_val;
            cur_phase <= PH_RED;
        end else if (step) begin
            unique case (cur_phase)
                PH_RED:  cur_phase <= PH_GRN;
                PH_GRN:  cur_phase <= PH_BLU;
                default: begin
                    cur_phase <= PH_RED;
                    cur_idx   <= cur_idx + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/pal_store.sv
// Module: pal_store
// Colour table: one register group per entry, with a write port for a single
// colour part, a part-select read port for the bus and a packed lookup port.
// Assumes: wr_entry is always inside the table; lookup entries past the end read zero.
module pal_store #(
    parameter int unsigned COMP_W  = 8,
    parameter int unsigned ENTRIES = 260,
    parameter int unsigned ENT_W   = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ENT_W-1:0]      wr_entry,
    input  pal_dac_pkg::phase_t   wr_phase,
    input  logic [COMP_W-1:0]     wr_val,
    input  logic [ENT_W-1:0]      rd_entry,
    input  pal_dac_pkg::phase_t   rd_phase,
    output logic [COMP_W-1:0]     rd_comp,
    input  logic [ENT_W-1:0]      pix_entry,
    output logic [3*COMP_W-1:0]   pix_rgb
);
    import pal_dac_pkg::*;

    localparam int unsigned RGB_W = 3 * COMP_W;

    logic [RGB_W-1:0] ent_rgb [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        localparam logic [COMP_W-1:0] RST_VAL = rst_is_white(e) ? '1 : '0;
        logic [COMP_W-1:0] red_q, grn_q, blu_q;
        logic              hit;

        assign hit = wr_en && (wr_entry == ENT_W'(e));

        // Reset to the entry's default colour, else take the addressed part
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                red_q <= RST_VAL;
                grn_q <= RST_VAL;
                blu_q <= RST_VAL;
            end else if (hit) begin
                unique case (wr_phase)
                    PH_RED:  red_q <= wr_val;
                    PH_GRN:  grn_q <= wr_val;
                    default: blu_q <= wr_val;
                endcase
            end
        end

        assign ent_rgb[e] = {red_q, grn_q, blu_q};
    end

    // Bus read: pick the part the phase names
    always_comb begin
        logic [RGB_W-1:0] sel;
        sel = (rd_entry < ENT_W'(ENTRIES)) ? ent_rgb[rd_entry] : '0;
        unique case (rd_phase)
            PH_RED:  rd_comp = sel[RGB_W-1 -: COMP_W];
            PH_GRN:  rd_comp = sel[2*COMP_W-1 -: COMP_W];
            default: rd_comp = sel[COMP_W-1:0];
        endcase
    end

    // Pixel lookup: packed colour, zero outside the table
    always_comb begin
        pix_rgb = (pix_entry < ENT_W'(ENTRIES)) ? ent_rgb[pix_entry] : '0;
    end

endmodule

// File: rtl/pal_dac_port.sv
// Module: pal_dac_port (top)
// Register-bus front end of the colour palette: index load, byte-serial
// main and overlay data ports, plus a combinational pixel lookup port.
// Assumes: one bus access per cycle; read data is valid in the same cycle.
module pal_dac_port #(
    parameter int unsigned BUS_W        = 32,
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned COMP_W       = 8,
    parameter int unsigned MAIN_ENTRIES = 256,
    parameter int unsigned OVL_ENTRIES  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic                               req_write,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic [BUS_W/8-1:0]                 req_be,
    input  logic [BUS_W-1:0]                   req_wdata,
    output logic [BUS_W-1:0]                   rsp_rdata,
    input  logic [$clog2(MAIN_ENTRIES+OVL_ENTRIES)-1:0] pix_entry,
    output logic [3*COMP_W-1:0]                pix_rgb
);
    import pal_dac_pkg::*;

    localparam int unsigned IDX_W   = $clog2(MAIN_ENTRIES);
    localparam int unsigned OVL_W   = $clog2(OVL_ENTRIES);
    localparam int unsigned ENTRIES = MAIN_ENTRIES + OVL_ENTRIES;
    localparam int unsigned ENT_W   = $clog2(ENTRIES);
    localparam int unsigned BE_W    = BUS_W / 8;

    logic              idx_load, main_wr, ovl_wr, main_rd;
    logic [IDX_W-1:0]  cur_idx;
    phase_t            cur_phase;
    logic [ENT_W-1:0]  wr_entry, rd_entry;
    logic [COMP_W-1:0] rd_comp, bus_byte;

    assign bus_byte = req_wdata[BUS_W-1 -: COMP_W];

    pal_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .idx_load  (idx_load),
        .main_wr   (main_wr),
        .ovl_wr    (ovl_wr),
        .main_rd   (main_rd)
    );

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_load  (idx_load),
        .load_val  (req_wdata[BUS_W-1 -: IDX_W]),
        .step      (main_wr || ovl_wr || main_rd),
        .cur_idx   (cur_idx),
        .cur_phase (cur_phase)
    );

    // Entry targeted by a data write: the index itself or an overlay alias
    always_comb begin
        rd_entry = ENT_W'(cur_idx);
        if (ovl_wr)
            wr_entry = ENT_W'(MAIN_ENTRIES) + ENT_W'(cur_idx[OVL_W-1:0]);
        else
            wr_entry = ENT_W'(cur_idx);
    end

    pal_store #(.COMP_W(COMP_W), .ENTRIES(ENTRIES), .ENT_W(ENT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (main_wr || ovl_wr),
        .wr_entry  (wr_entry),
        .wr_phase  (cur_phase),
        .wr_val    (bus_byte),
        .rd_entry  (rd_entry),
        .rd_phase  (cur_phase),
        .rd_comp   (rd_comp),
        .pix_entry (pix_entry),
        .pix_rgb   (pix_rgb)
    );

    // Read data: colour byte in the top lane for data-port reads, zero otherwise
    always_comb begin
        rsp_rdata = main_rd ? {rd_comp, {(BUS_W-COMP_W){1'b0}}} : '0;
    end

endmodule

// File: rtl/pal_dac_chk.sv
// Module: pal_dac_chk
// Cycle-level checks of the index/phase sequencing, bound into pal_dac_port.
// Assumes: phase encoding 0 = red, 1 = green, 2 = blue.
module pal_dac_chk #(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned IDX_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [BUS_W/8-1:0] req_be,
    input logic [BUS_W-1:0]   req_wdata,
    input logic [BUS_W-1:0]   rsp_rdata,
    input logic [IDX_W-1:0]   cur_idx,
    input logic [1:0]         cur_phase
);
    logic full, is_load, is_step, is_quiet_rd, is_dead_wr;

    always_comb begin
        full        = req_valid && (&req_be);
        is_load     = full && req_write && (req_addr == ADDR_W'(0));
        is_step     = full && ((req_write && (req_addr == ADDR_W'(4) || req_addr == ADDR_W'(12)))
                               || (!req_write && req_addr == ADDR_W'(4)));
        is_quiet_rd = req_valid && !req_write && !(full && req_addr == ADDR_W'(4));
        is_dead_wr  = req_valid && req_write && !is_load && !is_step;
    end

    // R1
    phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_phase != 2'd3);

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> (cur_idx == $past(req_wdata[BUS_W-1 -: IDX_W])) && (cur_phase == 2'd0));

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_step && cur_phase != 2'd2) |=> (cur_phase == $past(cur_phase) + 2'd1) && $stable(cur_idx));

    // R4
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_step && cur_phase == 2'd2) |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && (cur_phase == 2'd0));

    // R7
    quiet_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_quiet_rd |-> rsp_rdata == '0);

    // R7
    quiet_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_quiet_rd |=> $stable(cur_idx) && $stable(cur_phase));

    // R8
    dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_dead_wr |=> $stable(cur_idx) && $stable(cur_phase));

endmodule

bind pal_dac_port pal_dac_chk #(
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W),
    .IDX_W  ($clog2(MAIN_ENTRIES))
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .cur_idx   (cur_idx),
    .cur_phase (cur_phase)
);

// File: tb/pal_dac_port_tb_top.sv
// Bench for pal_dac_port: directed corner cases, then seeded random traffic,
// each result compared with a model of the table kept in the bench.
module pal_dac_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [8:0]  pix_entry = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    logic [7:0] m_r [260];
    logic [7:0] m_g [260];
    logic [7:0] m_b [260];
    logic [7:0] m_idx;
    int         m_ph;

    always #5 clk = ~clk;

    pal_dac_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .pix_entry (pix_entry),
        .pix_rgb   (pix_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int e = 0; e < 260; e++) begin
            logic [7:0] v;
            v = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
            m_r[e] = v; m_g[e] = v; m_b[e] = v;
        end
        m_idx = 8'd0;
        m_ph  = 0;
    endfunction

    function automatic void model_adv();
        if (m_ph == 2) begin
            m_ph = 0;
            m_idx = m_idx + 8'd1;
        end else begin
            m_ph = m_ph + 1;
        end
    endfunction

    function automatic logic [31:0] model_rdata(input logic wr, input logic [3:0] a, input logic [3:0] be);
        if (wr || be != 4'hF || a != 4'h4) return 32'h0;
        case (m_ph)
            0:       return {m_r[m_idx], 24'h0};
            1:       return {m_g[m_idx], 24'h0};
            default: return {m_b[m_idx], 24'h0};
        endcase
    endfunction

    function automatic void model_step(input logic wr, input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        int e;
        if (be != 4'hF) return;
        if (wr) begin
            if (a == 4'h0) begin
                m_idx = d[31:24];
                m_ph  = 0;
            end else if (a == 4'h4 || a == 4'hC) begin
                e = (a == 4'h4) ? int'(m_idx) : 256 + int'(m_idx[1:0]);
                case (m_ph)
                    0:       m_r[e] = d[31:24];
                    1:       m_g[e] = d[31:24];
                    default: m_b[e] = d[31:24];
                endcase
                model_adv();
            end
        end else if (a == 4'h4) begin
            model_adv();
        end
    endfunction

    function automatic logic [23:0] model_pix(input int e);
        if (e >= 260) return 24'h0;
        return {m_r[e], m_g[e], m_b[e]};
    endfunction

    // One bus access: drive at negedge, check read data, commit at posedge
    task automatic bus_op(input logic wr, input logic [3:0] a, input logic [31:0] d,
                          input logic [3:0] be, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        if (!wr) check(req, rsp_rdata, model_rdata(wr, a, be));
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        model_step(wr, a, d, be);
    endtask

    task automatic pix_chk(input int e, input string req);
        @(negedge clk);
        pix_entry = 9'(e);
        #1;
        check(req, {8'h0, pix_rgb}, {8'h0, model_pix(e)});
    endtask

    task automatic wr_byte(input logic [3:0] a, input logic [7:0] v, input string req);
        bus_op(1'b1, a, {v, 24'h5A5A5A}, 4'hF, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C3B4A));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents on the lookup port, including the white entries
        for (int e = 0; e < 260; e++) pix_chk(e, "R1 reset colour");
        check("R1 white 255", {8'h0, model_pix(255)}, 32'h00FFFFFF);
        // R9: out-of-range lookups
        pix_chk(260, "R9 beyond table");
        pix_chk(511, "R9 beyond table");
        // R1/R6: first data read returns red of entry 0 (zero)
        bus_op(1'b0, 4'h4, 32'h0, 4'hF, "R1 R6 reset read");
        bus_op(1'b1, 4'h0, 32'h00000000, 4'hF, "R2 reload");

        // R3/R10: write one entry, visible the next cycle
        bus_op(1'b1, 4'h0, 32'h0A000000, 4'hF, "R2 load 10");
        wr_byte(4'h4, 8'h11, "R3");
        wr_byte(4'h4, 8'h22, "R3");
        wr_byte(4'h4, 8'h33, "R3");
        pix_chk(10, "R10 entry 10 after write");
        check("R3 entry 10", {8'h0, model_pix(10)}, 32'h00112233);

        // R2: reload mid-sequence restarts at red
        wr_byte(4'h4, 8'h44, "R4 next entry");
        bus_op(1'b1, 4'h0, 32'h0B000000, 4'hF, "R2 load mid-phase");
        wr_byte(4'h4, 8'h55, "R2");
        wr_byte(4'h4, 8'h66, "R2");
        wr_byte(4'h4, 8'h77, "R2");
        pix_chk(11, "R2 entry 11 rewritten");
        check("R2 entry 11", {8'h0, model_pix(11)}, 32'h00556677);

        // R4: wrap from 255 to 0
        bus_op(1'b1, 4'h0, 32'hFF000000, 4'hF, "R2 load 255");
        wr_byte(4'h4, 8'h01, "R4");
        wr_byte(4'h4, 8'h02, "R4");
        wr_byte(4'h4, 8'h03, "R4");
        wr_byte(4'h4, 8'h99, "R4 wrapped to 0");
        pix_chk(255, "R4 entry 255");
        pix_chk(0, "R4 entry 0 after wrap");
        check("R4 entry 0 red", {24'h0, model_pix(0)[23:16]}, 32'h99);

        // R5: overlay alias through index low bits
        bus_op(1'b1, 4'h0, 32'h41000000, 4'hF, "R2 load 0x41");
        wr_byte(4'hC, 8'hA1, "R5");
        wr_byte(4'hC, 8'hA2, "R5");
        wr_byte(4'hC, 8'hA3, "R5");
        pix_chk(257, "R5 overlay 257");
        check("R5 overlay 257", {8'h0, model_pix(257)}, 32'h00A1A2A3);
        pix_chk(65, "R5 main 0x41 untouched");
        wr_byte(4'hC, 8'hB1, "R5");
        wr_byte(4'hC, 8'hB2, "R5");
        wr_byte(4'hC, 8'hB3, "R5");
        pix_chk(258, "R5 overlay 258 after index step");

        // R6: read sequence across entries 10 and 11
        bus_op(1'b1, 4'h0, 32'h0A000000, 4'hF, "R2 load 10");
        for (int k = 0; k < 4; k++) bus_op(1'b0, 4'h4, 32'h0, 4'hF, "R6 data read");

        // R7: quiet reads between data reads
        bus_op(1'b0, 4'h0, 32'h0, 4'hF, "R7 read offset 0");
        bus_op(1'b0, 4'hC, 32'h0, 4'hF, "R7 read offset C");
        bus_op(1'b0, 4'h8, 32'h0, 4'hF, "R7 read offset 8");
        bus_op(1'b0, 4'h4, 32'h0, 4'hF, "R7 sequence continues");

        // R8: ignored writes, then prove nothing moved
        bus_op(1'b1, 4'h8, 32'hEE000000, 4'hF, "R8 offset 8");
        bus_op(1'b1, 4'h5, 32'hEE000000, 4'hF, "R8 offset 5");
        bus_op(1'b1, 4'h4, 32'hEE000000, 4'h7, "R8 partial enables");
        bus_op(1'b1, 4'h0, 32'h20000000, 4'hE, "R8 partial index load");
        bus_op(1'b0, 4'h4, 32'h0, 4'h3, "R8 partial read");
        pix_chk(11, "R8 entry 11 intact");
        bus_op(1'b0, 4'h4, 32'h0, 4'hF, "R8 phase intact");
        bus_op(1'b0, 4'h4, 32'h0, 4'hF, "R8 phase intact");

        // Random mix of all access kinds
        for (int n = 0; n < 4000; n++) begin
            int kind;
            logic [3:0] a;
            logic [3:0] be;
            logic [31:0] d;
            kind = $urandom_range(0, 9);
            case (kind)
                0:       a = 4'h0;
                1, 2, 3: a = 4'h4;
                4, 5:    a = 4'hC;
                6:       a = 4'h8;
                default: a = 4'($urandom);
            endcase
            be = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'hF;
            d  = $urandom;
            bus_op(($urandom_range(0, 2) != 0), a, d, be, "R3 R5 R6 R7 R8 random");
            if (n % 16 == 0) pix_chk($urandom_range(0, 263), "R9 R10 random lookup");
        end
        for (int e = 0; e < 260; e++) pix_chk(e, "R9 final sweep");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule